// File: doc/BRIEF.md
# Zero-Compressed Cache Data Array

This block models one data sub-bank of a cache in which every byte lane of every stored word has a companion flag that marks the byte as zero. A write inspects each byte of the incoming word in the same cycle as the request. A byte that is all zero only sets its flag, and the byte's write enable is held off, so the storage cell for that byte is never touched. A nonzero byte clears its flag and is stored. On a read, only lanes whose flag is clear are fetched from storage. Flagged lanes are not fetched and are returned as 0x00. The flags travel with the data so that a receiver can rebuild the zero bytes.

Each access also reports which byte lanes really touched storage. A bench or a power model can therefore count the accesses that were saved. The block has one request port, serving either a read or a write per cycle. Read results appear one cycle after the request.

Top module: `zc_data_array`

## Requirements
- R1: After reset every flag of every word is set, so a read of any word not yet written returns rdata 0x00000000 with zib_out 4'hF and byte_access_mask 4'h0.
- R2: A write (req=1, we=1) sets flag i of the addressed word exactly when wdata[8i+7:8i] is zero, and clears it otherwise. Lane i covers bits 8i+7..8i, with lane 0 at the least significant byte. The flag is updated at the clock edge that ends the request cycle.
- R3: A write stores only its nonzero bytes. Zero bytes leave the storage unchanged, and only the nonzero lanes show as accessed.
- R4: A read (req=1, we=0) gives rvalid=1 in the next cycle, with rdata and zib_out for the addressed word. zib_out bit i is the flag of lane i.
- R5: In read data, a lane whose flag is set is 0x00. A lane whose flag is clear carries the last nonzero byte written to it.
- R6: byte_access_mask is valid in the cycle after each request. After a write it shows the lanes with nonzero write data. After a read it equals the inverse of the word's flags. After a cycle with no request it is 4'h0.
- R7: When rvalid is low, rdata is 0x00000000 and zib_out is 4'h0.
- R8: A read in the cycle right after a write to the same word returns the new value. A write in the cycle right after a read does not change that read's returned data.
- R9: Words at different addresses (index width IDX_W) are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | IDX_W | Word index |
| wdata | input | 32 | Write data |
| rvalid | output | 1 | Read result valid |
| rdata | output | 32 | Read data, zero lanes rebuilt |
| zib_out | output | 4 | Zero flags of the read word |
| byte_access_mask | output | 4 | Lanes that touched storage in the previous access |

## Verification
Two events can fall in the same cycle: the return of a read and the flag and data update of a write issued right behind it. The reverse order can also happen, where a write's commit meets a read issued the very next cycle. The bench provokes both with back-to-back read/write and write/read pairs to one address, using data in which some lanes are zero and others are not. A behavioural reference model, holding flags and bytes as plain arrays, predicts rdata, zib_out, rvalid and byte_access_mask every clock, and the bench compares them. The reference model uses the pre-write state for the read that was issued first.

// File: rtl/zc_pkg.sv
package zc_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;
endpackage

// File: rtl/zc_zero_detect.sv
module zc_zero_detect #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic [LANES*BYTE_W-1:0] word,
  output logic [LANES-1:0]        zero
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign zero[i] = (word[i*BYTE_W +: BYTE_W] == '0);
  end
endmodule

// File: rtl/zc_flag_store.sv
module zc_flag_store #(
  parameter int IDX_W = 4,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [LANES-1:0] wr_flags,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [LANES-1:0] rd_flags
);
  localparam int DEPTH = 1 << IDX_W;

  logic [LANES-1:0] flags_q [DEPTH];
  logic [LANES-1:0] flags_d [DEPTH];

  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      flags_d[k] = flags_q[k];
    end
    if (wr_en) begin
      flags_d[wr_addr] = wr_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        flags_q[k] <= '1;
      end
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        flags_q[k] <= flags_d[k];
      end
    end
  end

  assign rd_flags = flags_q[rd_addr];

  // R2: the flag word of a written index follows the zero pattern given
  p_flag_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> flags_q[$past(wr_addr)] == $past(wr_flags));
endmodule

// File: rtl/zc_byte_bank.sv
module zc_byte_bank #(
  parameter int IDX_W  = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic              ren,
  input  logic [IDX_W-1:0]  addr,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [BYTE_W-1:0] rbyte_q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] rbyte_d;

  always_ff @(posedge clk) begin
    if (wen) begin
      mem[addr] <= wbyte;
    end
  end

  always_comb begin
    rbyte_d = '0;
    if (ren) begin
      rbyte_d = mem[addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbyte_q <= '0;
    end else begin
      rbyte_q <= rbyte_d;
    end
  end

  // R3: storage is only ever written with a nonzero byte
  p_no_zero_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wen |-> (wbyte != '0));
  // R3: a lane never reads and writes its storage in one cycle
  p_single_use_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wen && ren));
endmodule

// File: rtl/zc_data_array.sv
module zc_data_array #(
  parameter int IDX_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req,
  input  logic                      we,
  input  logic [IDX_W-1:0]          addr,
  input  logic [zc_pkg::WORD_W-1:0] wdata,
  output logic                      rvalid,
  output logic [zc_pkg::WORD_W-1:0] rdata,
  output logic [zc_pkg::LANES-1:0]  zib_out,
  output logic [zc_pkg::LANES-1:0]  byte_access_mask
);
  import zc_pkg::*;

  logic [LANES-1:0] zero_lanes;
  logic [LANES-1:0] cur_flags;
  logic [LANES-1:0] lane_wen;
  logic [LANES-1:0] lane_ren;
  logic             wr_go;
  logic             rd_go;

  logic             rvalid_d;
  logic [LANES-1:0] zib_d;
  logic [LANES-1:0] mask_d;

  assign wr_go = req && we;
  assign rd_go = req && !we;

  zc_zero_detect #(.LANES(LANES), .BYTE_W(BYTE_W)) u_detect (
    .word (wdata),
    .zero (zero_lanes)
  );

  zc_flag_store #(.IDX_W(IDX_W), .LANES(LANES)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_go),
    .wr_addr  (addr),
    .wr_flags (zero_lanes),
    .rd_addr  (addr),
    .rd_flags (cur_flags)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_bank
    assign lane_wen[i] = wr_go && !zero_lanes[i];
    assign lane_ren[i] = rd_go && !cur_flags[i];

    zc_byte_bank #(.IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wen     (lane_wen[i]),
      .ren     (lane_ren[i]),
      .addr    (addr),
      .wbyte   (wdata[i*BYTE_W +: BYTE_W]),
      .rbyte_q (rdata[i*BYTE_W +: BYTE_W])
    );

    // R5: a flagged lane is always returned as zero
    p_flag_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      zib_out[i] |-> (rdata[i*BYTE_W +: BYTE_W] == '0));
  end

  always_comb begin
    rvalid_d = rd_go;
    zib_d    = rd_go ? cur_flags : '0;
    mask_d   = '0;
    if (req) begin
      mask_d = lane_wen | lane_ren;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid           <= 1'b0;
      zib_out          <= '0;
      byte_access_mask <= '0;
    end else begin
      rvalid           <= rvalid_d;
      zib_out          <= zib_d;
      byte_access_mask <= mask_d;
    end
  end

  // R4: every read request yields rvalid one cycle later
  p_read_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> rvalid);
  // R6: a read reports exactly the unflagged lanes as accessed
  p_mask_inverse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (byte_access_mask == ~zib_out));
  // R6: an idle cycle leaves no access reported
  p_idle_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (byte_access_mask == '0));
  // R7: outputs are quiet without a read result
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata == '0 && zib_out == '0));
endmodule

// File: tb/zc_data_array_test.sv
module zc_data_array_test;
  localparam int IDX_W = 4;
  localparam int DEPTH = 1 << IDX_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [IDX_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        rvalid;
  logic [31:0] rdata;
  logic [3:0]  zib_out;
  logic [3:0]  byte_access_mask;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [3:0]  m_flag [DEPTH];
  logic [31:0] m_data [DEPTH];
  logic        e_rvalid = 1'b0;
  logic [31:0] e_rdata = '0;
  logic [3:0]  e_zib = '0;
  logic [3:0]  e_mask = '0;
  logic [31:0] lfsr = 32'hACE1_2357;

  always #2.5 clk = ~clk;

  zc_data_array #(.IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rvalid(rvalid), .rdata(rdata), .zib_out(zib_out),
    .byte_access_mask(byte_access_mask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare outputs from the previous request, then issue a new one
  task automatic step(input logic r, input logic w, input logic [IDX_W-1:0] a,
                      input logic [31:0] d);
    @(negedge clk);
    chk("R4 rvalid", {31'b0, rvalid}, {31'b0, e_rvalid});
    chk("R5 rdata", rdata, e_rdata);
    chk("R2 zib_out", {28'b0, zib_out}, {28'b0, e_zib});
    chk("R6 mask", {28'b0, byte_access_mask}, {28'b0, e_mask});
    e_rvalid = r && !w;
    e_rdata  = '0;
    e_zib    = '0;
    e_mask   = '0;
    if (r && !w) begin
      e_zib = m_flag[a];
      for (int i = 0; i < 4; i++) begin
        if (!m_flag[a][i]) begin
          e_rdata[i*8 +: 8] = m_data[a][i*8 +: 8];
          e_mask[i] = 1'b1;
        end
      end
    end else if (r && w) begin
      for (int i = 0; i < 4; i++) begin
        if (d[i*8 +: 8] == 8'h00) begin
          m_flag[a][i] = 1'b1;
        end else begin
          m_flag[a][i] = 1'b0;
          m_data[a][i*8 +: 8] = d[i*8 +: 8];
          e_mask[i] = 1'b1;
        end
      end
    end
    req = r; we = w; addr = a; wdata = d;
  endtask

  function automatic logic [31:0] sparse(input logic [31:0] x);
    logic [31:0] v = x;
    for (int i = 0; i < 4; i++) begin
      if (x[i]) v[(i*8) +: 8] = 8'h00;
    end
    return v;
  endfunction

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      m_flag[k] = 4'hF;
      m_data[k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, reads of unwritten words
    step(1, 0, 4'd0, '0);
    step(1, 0, 4'd15, '0);
    step(0, 0, 4'd0, '0);
    // R2 R3: mixed zero and nonzero lanes
    step(1, 1, 4'd3, 32'h1100_3300);
    step(1, 0, 4'd3, '0);              // R8: read right after write
    step(1, 1, 4'd3, 32'h0000_0000);   // R8: write right after read
    step(1, 0, 4'd3, '0);
    // R5: stale byte behind a set flag must not reappear
    step(1, 1, 4'd4, 32'hAABB_CCDD);
    step(1, 1, 4'd4, 32'h00BB_00DD);
    step(1, 0, 4'd4, '0);
    step(1, 1, 4'd4, 32'hEE00_0000);
    step(1, 0, 4'd4, '0);
    // R9: neighbours stay independent
    step(1, 1, 4'd5, 32'hFFFF_FFFF);
    step(1, 0, 4'd4, '0);
    step(1, 0, 4'd6, '0);
    step(1, 0, 4'd5, '0);
    // R7: idle cycles between results
    step(0, 1, 4'd5, 32'h1234_5678);
    step(0, 0, 4'd5, '0);
    step(1, 0, 4'd5, '0);
    // mixed traffic with many zero lanes
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[7:5] != 3'd0, lfsr[8], lfsr[12:9],
           sparse({lfsr[3:0], lfsr[31:13], 9'h1A5} ^ {lfsr[15:0], lfsr[31:16]}));
    end
    step(0, 0, 4'd0, '0);
    step(0, 0, 4'd0, '0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule